// File: doc/BRIEF.md
# Shared Interrupt Flag Controller

This block gathers a set of interrupt sources coming from power-sequencing logic into one flag register. It drives a single active-low interrupt line to a management processor. Software reaches the block through a plain synchronous register bus with an address, a write strobe, write data and read data. The bus exposes four registers:

- a flag register that software clears by writing 1s,
- an enable mask,
- a read-only view of the synchronized source inputs,
- a write-only generate register that raises a software event on any source.

Each source is chosen at elaboration to be either edge-latched or level-following. An edge-latched source records a rising edge and holds it until software clears it. A level-following source, such as a power-controller alert pin, forces its flag to 1 for as long as its input is asserted. A level source that stays asserted can be silenced by clearing its enable bit; its flag stays visible.

Top module: `seq_irq_ctrl`

## Requirements
- R1: After reset, the flag register (address 0) reads 0, the enable register (address 1) reads 0, and `irq_n_o` is 1.
- R2: Every source input passes through two flip-flops. The live register (address 2) then shows its current, unlatched value in bit i for source i. Bits at and above NUM_SRC read 0.
- R3: For an edge-latched source, a rising edge of the synchronized input sets flag bit i. The flag then stays set after the input falls.
- R4: Writing to address 0 clears every flag bit whose write-data bit is 1. Flag bits whose write-data bit is 0 keep their value.
- R5: If an edge event and a clearing write reach the same flag bit in the same cycle, the flag ends up set.
- R6: For a level-following source (LEVEL_MASK bit set), the flag is 1 for every cycle that the synchronized input is 1, and a clearing write has no effect during that time. Once the input has returned to 0, the flag stays set until a clearing write removes it.
- R7: Writing a 1 to bit i of address 3 sets flag i in the same way a hardware edge does, for any kind of source. Address 3 always reads 0.
- R8: Bit i of the enable register (address 1) gates only the contribution of flag i to the interrupt. Flags keep updating and stay readable while masked.
- R9: `irq_n_o` is a register. It is 0 in the cycle after any flag is set with its enable bit set, and 1 in the cycle after no such flag exists. This holds for flags that set after software has read the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Raw interrupt source inputs, active high |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed register, combinational |
| irq_n_o | output | 1 | Shared interrupt line, active low |

## Verification
The bench builds the block with six sources, the top two level-following (LEVEL_MASK = 6'b110000), and an 8-bit data bus. With these values both generate variants of the flag cell are present in one instance. They also leave two data bits above the last source, which exercises the zero-fill of the read data. The small source count keeps the directed cases readable, among them the edge-versus-clear collision and the alert held across a clearing write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // Word offsets of the register window
   localparam int unsigned OFS_FLAG = 0;
   localparam int unsigned OFS_EN   = 1;
   localparam int unsigned OFS_LIVE = 2;
   localparam int unsigned OFS_GEN  = 3;
   localparam int unsigned MIN_ADDR_W = 2;

   typedef struct packed {
      logic wr_flag;
      logic wr_en;
      logic wr_gen;
   } wr_dec_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("irqc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_flag_cell.sv
module irqc_flag_cell #(
   parameter bit LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_i,
   input  logic gen_i,
   input  logic clr_i,
   output logic flag_o
);
   logic set_ev;
   logic flag_q;

   generate
      if (LEVEL) begin : g_level
         // level source: an asserted input re-sets the flag each cycle
         assign set_ev = sync_i | gen_i;

         a_r6_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
            sync_i |=> flag_o);
      end else begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= sync_i;
         end
         assign set_ev = (sync_i & ~prev_q) | gen_i;

         a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (sync_i && !prev_q) |=> flag_o);
      end
   endgenerate

   // set wins over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= set_ev | (flag_q & ~clr_i);
   end

   assign flag_o = flag_q;

   a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);
   a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev && clr_i) |=> flag_o);
   a_r7_gen_sets: assert property (@(posedge clk) disable iff (!rst_n)
      gen_i |=> flag_o);
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               we_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  rdata_o,
   input  logic [NUM_SRC-1:0] flags_i,
   input  logic [NUM_SRC-1:0] live_i,
   output logic [NUM_SRC-1:0] clr_o,
   output logic [NUM_SRC-1:0] gen_o,
   output logic [NUM_SRC-1:0] en_o
);
   wr_dec_t dec;
   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] wsrc;

   assign wsrc = wdata_i[NUM_SRC-1:0];

   generate
      if (DATA_W > NUM_SRC) begin : g_hi
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_SRC];
      end
   endgenerate

   always_comb begin
      dec = '0;
      if (we_i) begin
         dec.wr_flag = (addr_i == ADDR_W'(OFS_FLAG));
         dec.wr_en   = (addr_i == ADDR_W'(OFS_EN));
         dec.wr_gen  = (addr_i == ADDR_W'(OFS_GEN));
      end
   end

   assign clr_o = dec.wr_flag ? wsrc : '0;
   assign gen_o = dec.wr_gen  ? wsrc : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= '0;
      else if (dec.wr_en) en_q <= wsrc;
   end
   assign en_o = en_q;

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(OFS_FLAG))      rdata_o[NUM_SRC-1:0] = flags_i;
      else if (addr_i == ADDR_W'(OFS_EN))   rdata_o[NUM_SRC-1:0] = en_q;
      else if (addr_i == ADDR_W'(OFS_LIVE)) rdata_o[NUM_SRC-1:0] = live_i;
   end

   a_r8_enable_wr: assert property (@(posedge clk) disable iff (!rst_n)
      dec.wr_en |=> (en_o == $past(wsrc)));
   a_r8_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !dec.wr_en |=> $stable(en_o));
endmodule

// File: rtl/seq_irq_ctrl.sv
module seq_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned     NUM_SRC    = 8,
   parameter int unsigned     DATA_W     = 16,
   parameter int unsigned     ADDR_W     = 4,
   parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hC0,
   parameter int unsigned     SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic               bus_we_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   output logic               irq_n_o
);
   generate
      if (DATA_W < NUM_SRC) begin : g_chk_w
         $error("seq_irq_ctrl: DATA_W must cover NUM_SRC");
      end
      if (ADDR_W < MIN_ADDR_W) begin : g_chk_a
         $error("seq_irq_ctrl: ADDR_W too small for the register window");
      end
      if (NUM_SRC < 1) begin : g_chk_n
         $error("seq_irq_ctrl: NUM_SRC must be positive");
      end
   endgenerate

   logic [NUM_SRC-1:0] live;
   logic [NUM_SRC-1:0] flags;
   logic [NUM_SRC-1:0] clr;
   logic [NUM_SRC-1:0] gen;
   logic [NUM_SRC-1:0] en;
   logic               irq_n_q;

   irqc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (src_i),
      .q_o   (live)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
      irqc_flag_cell #(.LEVEL(LEVEL_MASK[i])) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .sync_i (live[i]),
         .gen_i  (gen[i]),
         .clr_i  (clr[i]),
         .flag_o (flags[i])
      );
   end

   irqc_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (bus_addr_i),
      .we_i    (bus_we_i),
      .wdata_i (bus_wdata_i),
      .rdata_o (bus_rdata_o),
      .flags_i (flags),
      .live_i  (live),
      .clr_o   (clr),
      .gen_o   (gen),
      .en_o    (en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n_q <= 1'b1;
      else        irq_n_q <= ~(|(flags & en));
   end
   assign irq_n_o = irq_n_q;

   a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flags & en)) |=> !irq_n_o);
   a_r9_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(flags & en)) |=> irq_n_o);
endmodule

// File: tb/seq_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module seq_irq_ctrl_tb_top;
   localparam int unsigned N  = 6;
   localparam int unsigned DW = 8;
   localparam int unsigned AW = 4;
   localparam logic [N-1:0] LVL = 6'b110000;
   localparam logic [AW-1:0] A_FLAG = 4'd0;
   localparam logic [AW-1:0] A_EN   = 4'd1;
   localparam logic [AW-1:0] A_LIVE = 4'd2;
   localparam logic [AW-1:0] A_GEN  = 4'd3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src = '0;
   logic [AW-1:0] addr = '0;
   logic          we = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq_n;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   seq_irq_ctrl #(.NUM_SRC(N), .DATA_W(DW), .ADDR_W(AW), .LEVEL_MASK(LVL)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr_i(addr),
      .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_n_o(irq_n)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // all bus actions start and end just after a falling edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(posedge clk); @(negedge clk);
      we = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      addr = a; we = 1'b0;
      #2 d = rdata;
   endtask

   task automatic cyc(input int n);
      for (int k = 0; k < n; k++) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic t_reset();
      logic [DW-1:0] d;
      rd(A_FLAG, d); check("R1 flags", d, 0);
      rd(A_EN, d);   check("R1 enable", d, 0);
      check("R1 irq_n", irq_n, 1);
   endtask

   task automatic t_live_edge();
      logic [DW-1:0] d;
      src = 6'b101001;
      cyc(1); rd(A_LIVE, d); check("R2 live after one stage", d, 0);
      cyc(1); rd(A_LIVE, d); check("R2 live after two stages", d, 8'h29);
      cyc(1); rd(A_FLAG, d); check("R3 R6 flags latched", d, 8'h29);
      src = '0;
      cyc(3); rd(A_LIVE, d); check("R2 live follows low", d, 0);
      rd(A_FLAG, d); check("R3 flags held after fall", d, 8'h29);
      wr(A_FLAG, 8'h01);
      rd(A_FLAG, d); check("R4 zero bits keep", d, 8'h28);
      wr(A_FLAG, 8'hFF);
      rd(A_FLAG, d); check("R4 ones clear", d, 0);
      check("R8 masked irq stayed high", irq_n, 1);
   endtask

   task automatic t_level();
      logic [DW-1:0] d;
      src[4] = 1'b1;
      cyc(3);
      wr(A_FLAG, 8'h10);
      rd(A_FLAG, d); check("R6 clear ignored while asserted", d, 8'h10);
      check("R8 masked flag no irq", irq_n, 1);
      wr(A_EN, 8'h10);
      check("R9 irq one cycle later, not yet", irq_n, 1);
      cyc(1); check("R9 irq asserted", irq_n, 0);
      wr(A_EN, 8'h00);
      cyc(1); check("R8 mask silences irq", irq_n, 1);
      rd(A_FLAG, d); check("R8 flag readable while masked", d, 8'h10);
      src[4] = 1'b0;
      cyc(3);
      rd(A_FLAG, d); check("R6 flag sticky after release", d, 8'h10);
      wr(A_FLAG, 8'h10);
      rd(A_FLAG, d); check("R6 clear after release", d, 0);
   endtask

   task automatic t_gen();
      logic [DW-1:0] d;
      wr(A_GEN, 8'h22);
      rd(A_GEN, d);  check("R7 generate reads zero", d, 0);
      rd(A_FLAG, d); check("R7 generate sets edge and level", d, 8'h22);
      rd(A_LIVE, d); check("R7 live untouched", d, 0);
      wr(A_FLAG, 8'h22);
      rd(A_FLAG, d); check("R7 generated flags clear", d, 0);
   endtask

   task automatic t_collide();
      logic [DW-1:0] d;
      wr(A_GEN, 8'h01);
      src[0] = 1'b1;
      @(posedge clk); @(negedge clk);        // stage 1
      addr = A_FLAG; wdata = 8'h01; we = 1'b1;
      @(posedge clk); @(negedge clk);        // stage 2, clear sits ready
      @(posedge clk); @(negedge clk);        // edge and clear together
      we = 1'b0; wdata = '0;
      rd(A_FLAG, d); check("R5 set beats clear", d, 8'h01);
      src[0] = 1'b0;
      cyc(3);
      wr(A_FLAG, 8'h01);
      rd(A_FLAG, d); check("R5 plain clear works", d, 0);
   endtask

   task automatic t_late();
      logic [DW-1:0] d;
      wr(A_EN, 8'h03);
      wr(A_GEN, 8'h01);
      cyc(1); check("R9 irq on first flag", irq_n, 0);
      rd(A_FLAG, d); check("R9 handler sees bit 0", d, 8'h01);
      wr(A_GEN, 8'h02);
      wr(A_FLAG, 8'h01);
      cyc(1); check("R9 late flag keeps irq low", irq_n, 0);
      rd(A_FLAG, d); check("R9 late flag visible", d, 8'h02);
      wr(A_FLAG, 8'h02);
      check("R9 irq still low one cycle", irq_n, 0);
      cyc(1); check("R9 irq released", irq_n, 1);
      wr(A_EN, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 irq_n during reset", irq_n, 1);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_live_edge();
      t_level();
      t_gen();
      t_collide();
      t_late();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule